// File: doc/BRIEF.md
# Memory Region Security Filter

The filter decides, for every memory access, whether a non-secure initiator must be stopped. It holds eight programmable address windows, each described by an inclusive first and last megabyte number, a secure marker and an enable. A ninth, implicit window stands for all memory that no enabled window claims and carries its own secure marker. A global pass-through control disables every restriction at once.

Configuration arrives on a simple write port that carries a register index and a 32-bit word. The low half is the data and the high half a bit-wise write mask, so software can set bounds, then the secure marker, then the enable, each in a separate write that leaves the other bits alone. Every access presented with a valid strobe is answered exactly one clock later with a block decision and the number of the lowest matching window, or 8 when no window matches.

Top module: `memsec_filter`

## Requirements
- R1: After reset every window is disabled, the outside window is non-secure and pass-through is off, so no access is blocked and every response reports window 8.
- R2: A write updates data bit i (0..15) only where mask bit 16+i of the word is 1; a word whose upper half is zero leaves the register unchanged.
- R3: Window n (0..7) keeps its first megabyte in bits [11:0] of register 6+2n, its secure marker in bit 14 and its enable in bit 15 of that register, and its last megabyte in bits [11:0] of register 7+2n; writes to any index outside 6..21 have no effect.
- R4: Window n matches an address when enabled and first <= addr[31:20] <= last, both bounds included; a window whose first exceeds its last matches nothing.
- R5: A non-secure access is blocked when it matches any enabled window whose secure marker is 1; matching only windows with a clear marker does not block.
- R6: Bit 14 of register 21 is the outside marker: when 1, a non-secure access that matches no enabled window is blocked.
- R7: Bit 15 of register 21 is pass-through: when 1, no access is blocked.
- R8: An access flagged secure is never blocked.
- R9: The response reports the lowest-numbered matching enabled window, or 8 when none matches.
- R10: The response valid follows the access valid by exactly one cycle, and the decision uses the configuration held before any write in the same cycle as the access.
- R11: When the response valid is low, the block flag is 0 and the reported window is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIdx | input | 5 | Configuration register index |
| cfgData | input | 32 | Write word: mask in [31:16], data in [15:0] |
| accValid | input | 1 | Access address is valid |
| accAddr | input | 32 | Byte address of the access |
| accSecure | input | 1 | Access comes from a secure initiator |
| rspValid | output | 1 | Decision is valid |
| rspBlock | output | 1 | Access must be blocked |
| rspRegion | output | 4 | Lowest matching window, 8 for none |

## Verification
The hardest situations to reach are windows that overlap with different secure markers, and an access landing in the same cycle as the write that changes the window it touches. Directed writes build two nested windows with opposite markers and a reversed window, and an access is issued in the very cycle of an enable write. A long random phase then mixes partially masked writes, restricted to a narrow band of megabyte numbers, with accesses in that same band so that bounds, overlaps and the outside window keep colliding.

// File: rtl/memsec_pkg.sv
package memsec_pkg;
  localparam int NUM_RGN = 8;
  localparam int FIELD_W = 12;

  typedef struct packed {
    logic [NUM_RGN-1:0] rgnEn;
    logic [NUM_RGN-1:0] rgnSec;
    logic               outSec;
    logic               bypass;
  } ctlStrobe_t;
endpackage

// File: rtl/memsec_regs.sv
module memsec_regs
  import memsec_pkg::*;
#(
  parameter int IDX_W    = 5,
  parameter int REG_BASE = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cfgWe,
  input  logic [IDX_W-1:0]             cfgIdx,
  input  logic [31:0]                  cfgData,
  output ctlStrobe_t                   strobe,
  output logic [NUM_RGN-1:0][FIELD_W-1:0] startB,
  output logic [NUM_RGN-1:0][FIELD_W-1:0] endB
);
  localparam int NUM_REG = 2 * NUM_RGN;
  localparam logic [IDX_W-1:0] BASE_L = IDX_W'(REG_BASE);
  localparam logic [IDX_W-1:0] LAST_L = IDX_W'(REG_BASE + NUM_REG - 1);

  logic [NUM_REG-1:0][15:0] regFile;
  logic [IDX_W-1:0]         relIdx;
  logic                     inMap;
  logic [15:0]              wMask;
  logic [15:0]              wData;

  assign relIdx = cfgIdx - BASE_L;
  assign inMap  = (cfgIdx >= BASE_L) && (cfgIdx <= LAST_L);
  assign wMask  = cfgData[31:16];
  assign wData  = cfgData[15:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regFile <= '0;
    end else if (cfgWe && inMap) begin
      for (int k = 0; k < NUM_REG; k++) begin
        if (relIdx == IDX_W'(k))
          regFile[k] <= (regFile[k] & ~wMask) | (wData & wMask);
      end
    end
  end

  logic [NUM_RGN-1:0] unusedBits;
  for (genvar n = 0; n < NUM_RGN; n++) begin : g_rgn
    assign startB[n]       = regFile[2*n][FIELD_W-1:0];
    assign endB[n]         = regFile[2*n+1][FIELD_W-1:0];
    assign strobe.rgnSec[n] = regFile[2*n][14];
    assign strobe.rgnEn[n]  = regFile[2*n][15];
    assign unusedBits[n]   = ^regFile[2*n][13:FIELD_W] ^ ^regFile[2*n+1][13:FIELD_W];
  end
  assign strobe.outSec = regFile[NUM_REG-1][14];
  assign strobe.bypass = regFile[NUM_REG-1][15];

  logic unusedUpper;
  assign unusedUpper = ^unusedBits ^ ^regFile[NUM_REG-3:0] ^ ^regFile[NUM_REG-2][15:14];

  // R2: a write whose mask half is empty changes nothing
  a_r2_empty_mask_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgData[31:16] == 16'h0) |=> $stable(regFile));

  // R3: indices outside the map are ignored
  a_r3_foreign_index_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && (cfgIdx < BASE_L || cfgIdx > LAST_L)) |=> $stable(regFile));
endmodule

// File: rtl/memsec_match.sv
module memsec_match
  import memsec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RGN_W  = $clog2(NUM_RGN + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            accValid,
  input  logic [ADDR_W-1:0]               accAddr,
  input  logic                            accSecure,
  input  ctlStrobe_t                      strobe,
  input  logic [NUM_RGN-1:0][FIELD_W-1:0] startB,
  input  logic [NUM_RGN-1:0][FIELD_W-1:0] endB,
  output logic                            rspValid,
  output logic                            rspBlock,
  output logic [RGN_W-1:0]                rspRegion
);
  localparam int LOW_W = ADDR_W - FIELD_W;
  localparam logic [RGN_W-1:0] NONE = RGN_W'(NUM_RGN);

  logic [FIELD_W-1:0] mbNum;
  logic [NUM_RGN-1:0] hitVec;
  logic [RGN_W-1:0]   firstHit;
  logic               secHit;
  logic               blockNow;
  logic               unusedLow;

  assign mbNum     = accAddr[ADDR_W-1:LOW_W];
  assign unusedLow = ^accAddr[LOW_W-1:0];

  for (genvar n = 0; n < NUM_RGN; n++) begin : g_cmp
    assign hitVec[n] = strobe.rgnEn[n] && (mbNum >= startB[n]) && (mbNum <= endB[n]);
  end

  always_comb begin
    firstHit = NONE;
    for (int n = NUM_RGN - 1; n >= 0; n--) begin
      if (hitVec[n]) firstHit = RGN_W'(n);
    end
  end

  assign secHit   = |(hitVec & strobe.rgnSec);
  assign blockNow = accValid && !accSecure && !strobe.bypass &&
                    (secHit || (hitVec == '0 && strobe.outSec));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspBlock  <= 1'b0;
      rspRegion <= NONE;
    end else begin
      rspValid  <= accValid;
      rspBlock  <= blockNow;
      rspRegion <= accValid ? firstHit : NONE;
    end
  end

  a_r8_secure_never_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accSecure) |=> !rspBlock);

  a_r7_bypass_never_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && strobe.bypass) |=> !rspBlock);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    accValid |=> rspValid);

  a_r11_idle_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspBlock && rspRegion == NONE));

  a_r9_region_in_range: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspRegion <= NONE));
endmodule

// File: rtl/memsec_filter.sv
module memsec_filter
  import memsec_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 5,
  parameter int REG_BASE = 6,
  parameter int RGN_W    = $clog2(NUM_RGN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [31:0]       cfgData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accSecure,
  output logic              rspValid,
  output logic              rspBlock,
  output logic [RGN_W-1:0]  rspRegion
);
  ctlStrobe_t                      strobe;
  logic [NUM_RGN-1:0][FIELD_W-1:0] startB;
  logic [NUM_RGN-1:0][FIELD_W-1:0] endB;

  memsec_regs #(.IDX_W(IDX_W), .REG_BASE(REG_BASE)) u_regs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .strobe(strobe), .startB(startB), .endB(endB)
  );

  memsec_match #(.ADDR_W(ADDR_W), .RGN_W(RGN_W)) u_match (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr),
    .accSecure(accSecure), .strobe(strobe), .startB(startB), .endB(endB),
    .rspValid(rspValid), .rspBlock(rspBlock), .rspRegion(rspRegion)
  );
endmodule

// File: tb/memsec_filter_bench.sv
module memsec_filter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [4:0]  cfgIdx = '0;
  logic [31:0] cfgData = '0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic        accSecure = 1'b0;
  logic        rspValid;
  logic        rspBlock;
  logic [3:0]  rspRegion;

  always #10 clk = ~clk;

  memsec_filter u_memsec_filter (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .accValid(accValid), .accAddr(accAddr), .accSecure(accSecure),
    .rspValid(rspValid), .rspBlock(rspBlock), .rspRegion(rspRegion)
  );

  int    nCmp = 0;
  int    nBad = 0;
  bit    done = 0;
  int    cfg [32];
  bit    armed = 0;
  bit    expValid, expBlock;
  int    expRegion;
  string expTag;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired act=running exp=finished");
    summary();
  end

  task automatic compare();
    if (!armed) return;
    nCmp++;
    if (rspValid !== expValid || rspBlock !== expBlock || int'(rspRegion) != expRegion) begin
      nBad++;
      if (rspValid !== expValid)
        $display("FAIL R10 rspValid act=%0b exp=%0b", rspValid, expValid);
      if (rspBlock !== expBlock)
        $display("FAIL %s rspBlock act=%0b exp=%0b", expTag, rspBlock, expBlock);
      if (int'(rspRegion) != expRegion)
        $display("FAIL %s rspRegion act=%0d exp=%0d", expTag, rspRegion, expRegion);
    end
  endtask

  // reference decision from the requirements
  task automatic predict(bit rst, bit v, logic [31:0] a, bit s, string tag);
    int  mb, lo, hi, first;
    bit  anySec, anyHit;
    expTag = tag;
    armed  = 1;
    if (!rst || !v) begin
      expValid = rst && v; expBlock = 0; expRegion = 8;   // R1, R11
      return;
    end
    mb = int'(a >> 20);
    first = 8; anySec = 0; anyHit = 0;
    for (int n = 0; n < 8; n++) begin
      lo = cfg[6 + 2*n] & 'hfff;
      hi = cfg[7 + 2*n] & 'hfff;
      if (cfg[6 + 2*n][15] && mb >= lo && mb <= hi) begin
        anyHit = 1;
        if (first == 8) first = n;
        if (cfg[6 + 2*n][14]) anySec = 1;
      end
    end
    expValid  = 1;
    expRegion = first;
    expBlock  = !s && !cfg[21][15] && (anySec || (!anyHit && cfg[21][14]));
  endtask

  task automatic step(bit rst, bit we, int idx, logic [31:0] data,
                      bit v, logic [31:0] a, bit s, string tag);
    int m;
    @(negedge clk);
    compare();
    rstN = rst; cfgWe = we; cfgIdx = 5'(idx); cfgData = data;
    accValid = v; accAddr = a; accSecure = s;
    predict(rst, v, a, s, tag);
    if (rst && we && idx >= 6 && idx <= 21) begin
      m = int'(data[31:16]);
      cfg[idx] = (cfg[idx] & ~m) | (int'(data[15:0]) & m);
    end
  endtask

  task automatic wr(int idx, int mask, int val, string tag);
    step(1, 1, idx, {16'(mask), 16'(val)}, 0, 0, 0, tag);
  endtask

  task automatic acc(logic [31:0] a, bit s, string tag);
    step(1, 0, 0, 0, 1, a, s, tag);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) cfg[i] = 0;
    // R1: outputs held in reset, then quiet configuration after it
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 32'h0, 0, "R1");
    acc(32'h0000_0000, 0, "R1");
    acc(32'h8000_0000, 0, "R1");
    acc(32'hFFFF_FFFF, 0, "R1");
    // R3: window 0 bounds [0,31] then marker, then enable, separately
    wr(6, 'h0fff, 'h0000, "R3");
    wr(7, 'h0fff, 31, "R3");
    wr(6, 'h4000, 'h4000, "R2");
    acc(32'h0000_0000, 0, "R2");
    // R10: access in the same cycle as the enable write sees old state
    step(1, 1, 6, 32'h8000_8000, 1, 32'h0000_0000, 0, "R10");
    acc(32'h0000_0000, 0, "R5");
    acc(32'h01FF_FFFF, 0, "R4");
    acc(32'h0200_0000, 0, "R4");
    acc(32'h0000_1234, 1, "R8");
    // R2: empty mask leaves window 0 intact
    wr(6, 'h0000, 'hffff, "R2");
    wr(7, 'h0000, 'h0000, "R2");
    acc(32'h0100_0000, 0, "R2");
    // R4: reversed window 1 matches nothing
    wr(8, 'hffff, 'hC000 | 100, "R4");
    wr(9, 'hffff, 50, "R4");
    acc(32'h04B0_0000, 0, "R4");
    // R9: overlapping windows 2 (plain) and 3 (secure)
    wr(10, 'hffff, 'h8000 | 200, "R9");
    wr(11, 'hffff, 300, "R9");
    wr(12, 'hffff, 'hC000 | 250, "R9");
    wr(13, 'hffff, 260, "R9");
    acc(32'(255) << 20, 0, "R9");
    acc(32'(210) << 20, 0, "R5");
    acc(32'(300) << 20 | 32'hFFFFF, 0, "R4");
    // R3: foreign indices
    wr(5, 'hffff, 'hffff, "R3");
    wr(22, 'hffff, 'hffff, "R3");
    wr(0, 'hffff, 'hffff, "R3");
    acc(32'h8000_0000, 0, "R3");
    acc(32'(210) << 20, 0, "R3");
    // R6: outside marker
    wr(21, 'h4000, 'h4000, "R6");
    acc(32'h8000_0000, 0, "R6");
    acc(32'(210) << 20, 0, "R6");
    acc(32'h8000_0000, 1, "R8");
    // R7: pass-through
    wr(21, 'h8000, 'h8000, "R7");
    acc(32'h8000_0000, 0, "R7");
    acc(32'h0000_0000, 0, "R7");
    wr(21, 'h8000, 'h0000, "R7");
    acc(32'h0000_0000, 0, "R7");
    // R11: idle
    step(1, 0, 0, 0, 0, 32'h0000_0000, 0, "R11");
    step(1, 0, 0, 0, 0, 32'h0000_0000, 0, "R11");
    // random mix in a narrow band of megabyte numbers
    for (int i = 0; i < 4000; i++) begin
      int idx;
      logic [31:0] d, a;
      idx = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 31) : $urandom_range(6, 21);
      d = {$urandom_range(0, 65535) > 20000 ? 16'($urandom) : 16'h0,
           16'($urandom & 'hC000) | 16'($urandom_range(0, 40))};
      a = (32'($urandom_range(0, 45)) << 20) | 32'($urandom & 'hFFFFF);
      step(1, $urandom_range(0, 2) == 0, idx, d, $urandom_range(0, 3) != 0, a,
           $urandom_range(0, 4) == 0, "R9");
    end
    step(1, 0, 0, 0, 0, 0, 0, "R11");
    @(negedge clk);
    compare();
    summary();
  end
endmodule